// File: doc/BRIEF.md
# Dual-Channel Sample Serializer with Frame and Bit Clocks

This block takes one 12-bit conversion result per channel from two converter channels on every frame and shifts each one out on serial lanes, two lanes per channel. Alongside the data it drives a bit clock and a frame clock. A receiver uses the frame clock to find word boundaries and the bit clock to time its captures. The block runs from a fast clock at twice the serial bit rate: each serial bit lasts two clock cycles. The sample source raises a one-cycle valid strobe whenever it has a new pair ready.

Three configuration inputs shape the stream. The first chooses between split operation, where each word travels as two 6-bit halves on two lanes, and single-lane operation, where the whole 12-bit word leaves on one lane and the frame is twice as long. The second chooses whether each lane's portion begins with its most or least significant bit. The third chooses between two's-complement and offset-binary coding. The block samples all three only at a frame boundary.

Top module: `adc_serial_fmt`

## Requirements
- R1: While reset is held and until the first frame completes, every lane is low, frameClk is high and bitClk is low. The active format after reset is split mode, MSB first, two's complement.
- R2: Each serial bit lasts two clock cycles. bitClk is low in the first cycle of a bit and high in the second, and lane values do not change while bitClk is high.
- R3: In split mode (cfgTwoLane=1) a frame is 6 bits (12 clock cycles). Lane A of a channel carries word bits 11..6 and lane B carries bits 5..0.
- R4: In single-lane mode (cfgTwoLane=0) a frame is 12 bits (24 clock cycles). Lane A carries all of bits 11..0 and lane B stays low.
- R5: With cfgLsbFirst=0 each lane sends the highest-numbered bit of its portion first. With cfgLsbFirst=1 it sends the lowest-numbered bit first.
- R6: With cfgOffsetBin=1 the serialized word is the sample with bit 11 inverted. With cfgOffsetBin=0 it is the sample unchanged.
- R7: frameClk is high during the first half of a frame's bits and low during the second half. It rises in the first cycle of the first bit of each frame.
- R8: A change on any configuration input in the middle of a frame does not affect that frame's length, order or coding. It takes effect from the next frame.
- R9: Each frame carries the most recent pair presented with sampleValid before the frame began, including a strobe in the frame's final cycle. If no strobe arrives, the previous pair is repeated. Sample inputs without sampleValid are ignored.
- R10: The two channels are serialized independently. Channel 0 uses samples[11:0] and lane bit 0; channel 1 uses samples[23:12] and lane bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per serial bit |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe marking a new sample pair on samples |
| samples | input | 24 | Channel 1 word in [23:12], channel 0 word in [11:0] |
| cfgTwoLane | input | 1 | 1 = split over two lanes, 0 = single lane |
| cfgLsbFirst | input | 1 | 1 = lowest-numbered bit of each portion first |
| cfgOffsetBin | input | 1 | 1 = offset-binary output, 0 = two's complement |
| laneA | output | 2 | First serial lane, one bit per channel |
| laneB | output | 2 | Second serial lane, one bit per channel |
| frameClk | output | 1 | Frame clock, high for first half of each frame |
| bitClk | output | 1 | Bit clock, rising in the middle of each bit |

## Verification
The hardest situations to reach from the ports are the ones inside a frame. These are a configuration change arriving after a frame has started, and several valid strobes landing between two frame boundaries. In both cases the effect must show up only on the following frame. The bench recovers words by deserializing the lanes against frameClk and bitClk. It runs a capture in parallel with a second thread that changes the configuration, or pulses sampleValid twice, at chosen bit positions. It then checks that the current frame kept its format and contents, that the next frame used the new format and the latest strobed pair, and that the frame after that repeats the pair.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  // Largest word width the index fields are sized for.
  localparam int MAX_SAMPLE_W = 16;
  localparam int IDX_W        = $clog2(MAX_SAMPLE_W);

  // Strobes and frame-scoped settings handed from control to datapath.
  typedef struct packed {
    logic             loadFrame;  // last cycle of a frame: latch next word
    logic             twoLane;    // active split mode for the current frame
    logic             lsbFirst;   // active bit order for the current frame
    logic             offsetBin;  // active output coding for the current frame
    logic [IDX_W-1:0] bitIdx;     // bit position within the frame
  } fmtCtrl_t;

endpackage

// File: rtl/adc_fmt_ctrl.sv
module adc_fmt_ctrl
  import adc_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfgTwoLane,
  input  logic     cfgLsbFirst,
  input  logic     cfgOffsetBin,
  output fmtCtrl_t ctrl,
  output logic     frameClk,
  output logic     bitClk
);

  localparam int HALF_W = SAMPLE_W / 2;
  localparam int CYC_W  = $clog2(2 * SAMPLE_W);

  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] lastCyc;
  logic [CYC_W-1:0] halfCyc;
  logic             actTwoLane;
  logic             actLsbFirst;
  logic             actOffsetBin;
  logic             frameEnd;

  // Frame length in cycles follows the format latched for this frame.
  assign lastCyc  = actTwoLane ? CYC_W'(2 * HALF_W - 1) : CYC_W'(2 * SAMPLE_W - 1);
  assign halfCyc  = actTwoLane ? CYC_W'(HALF_W) : CYC_W'(SAMPLE_W);
  assign frameEnd = (cyc == lastCyc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc          <= '0;
      actTwoLane   <= 1'b1;
      actLsbFirst  <= 1'b0;
      actOffsetBin <= 1'b0;
    end else if (frameEnd) begin
      cyc          <= '0;
      actTwoLane   <= cfgTwoLane;
      actLsbFirst  <= cfgLsbFirst;
      actOffsetBin <= cfgOffsetBin;
    end else begin
      cyc <= cyc + CYC_W'(1);
    end
  end

  always_comb begin
    ctrl.loadFrame = frameEnd;
    ctrl.twoLane   = actTwoLane;
    ctrl.lsbFirst  = actLsbFirst;
    ctrl.offsetBin = actOffsetBin;
    ctrl.bitIdx    = IDX_W'(cyc >> 1);
  end

  // Bit clock: low in the first cycle of a bit, high in the second.
  assign bitClk   = cyc[0];
  // Frame clock: high through the first half of the frame's bits.
  assign frameClk = (cyc < halfCyc);

endmodule

// File: rtl/adc_fmt_datapath.sv
module adc_fmt_datapath
  import adc_fmt_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  fmtCtrl_t                   ctrl,
  output logic [NUM_CH-1:0]          laneA,
  output logic [NUM_CH-1:0]          laneB
);

  localparam int HALF_W = SAMPLE_W / 2;

  logic [IDX_W-1:0] posA;
  logic [IDX_W-1:0] posB;

  // Bit positions are shared by all channels.
  always_comb begin
    if (ctrl.twoLane) begin
      posA = ctrl.lsbFirst ? IDX_W'(HALF_W) + ctrl.bitIdx
                           : IDX_W'(SAMPLE_W - 1) - ctrl.bitIdx;
    end else begin
      posA = ctrl.lsbFirst ? ctrl.bitIdx
                           : IDX_W'(SAMPLE_W - 1) - ctrl.bitIdx;
    end
    posB = ctrl.lsbFirst ? ctrl.bitIdx : IDX_W'(HALF_W - 1) - ctrl.bitIdx;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] inWord;
    logic [SAMPLE_W-1:0] pendWord;
    logic [SAMPLE_W-1:0] frameWord;
    logic [SAMPLE_W-1:0] codedWord;

    assign inWord = samples[ch*SAMPLE_W +: SAMPLE_W];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pendWord  <= '0;
        frameWord <= '0;
      end else begin
        if (sampleValid) begin
          pendWord <= inWord;
        end
        if (ctrl.loadFrame) begin
          frameWord <= sampleValid ? inWord : pendWord;
        end
      end
    end

    // Offset binary differs from two's complement only in the top bit.
    assign codedWord = {frameWord[SAMPLE_W-1] ^ ctrl.offsetBin, frameWord[SAMPLE_W-2:0]};

    assign laneA[ch] = codedWord[posA];
    assign laneB[ch] = ctrl.twoLane & codedWord[posB];
  end

endmodule

// File: rtl/adc_serial_fmt.sv
module adc_serial_fmt
  import adc_fmt_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  logic                       cfgTwoLane,
  input  logic                       cfgLsbFirst,
  input  logic                       cfgOffsetBin,
  output logic [NUM_CH-1:0]          laneA,
  output logic [NUM_CH-1:0]          laneB,
  output logic                       frameClk,
  output logic                       bitClk
);

  fmtCtrl_t ctrlBus;
  logic     activeTwoLane;
  logic     activeLsbFirst;
  logic     frameLoad;

  adc_fmt_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgTwoLane  (cfgTwoLane),
    .cfgLsbFirst (cfgLsbFirst),
    .cfgOffsetBin(cfgOffsetBin),
    .ctrl        (ctrlBus),
    .frameClk    (frameClk),
    .bitClk      (bitClk)
  );

  adc_fmt_datapath #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .samples    (samples),
    .ctrl       (ctrlBus),
    .laneA      (laneA),
    .laneB      (laneB)
  );

  // Frame-scoped state made visible for the bound checker.
  assign activeTwoLane  = ctrlBus.twoLane;
  assign activeLsbFirst = ctrlBus.lsbFirst;
  assign frameLoad      = ctrlBus.loadFrame;

endmodule

// File: rtl/adc_fmt_chk.sv
module adc_fmt_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frameClk,
  input logic              bitClk,
  input logic [NUM_CH-1:0] laneA,
  input logic [NUM_CH-1:0] laneB,
  input logic              twoLane,
  input logic              lsbFirst,
  input logic              loadFrame
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  bit_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    bitClk != $past(bitClk));

  // R2
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    bitClk |-> ($stable(laneA) && $stable(laneB)));

  // R4
  laneb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !twoLane |-> (laneB == '0));

  // R7
  frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(frameClk) |-> ($past(loadFrame) && !bitClk));

  // R7
  frame_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(frameClk) |-> !bitClk);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(loadFrame) |-> ($stable(twoLane) && $stable(lsbFirst)));

endmodule

bind adc_serial_fmt adc_fmt_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frameClk (frameClk),
  .bitClk   (bitClk),
  .laneA    (laneA),
  .laneB    (laneB),
  .twoLane  (activeTwoLane),
  .lsbFirst (activeLsbFirst),
  .loadFrame(frameLoad)
);

// File: tb/adc_serial_fmt_bench.sv
module adc_serial_fmt_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] samples = '0;
  logic        cfgTwoLane = 1'b1;
  logic        cfgLsbFirst = 1'b0;
  logic        cfgOffsetBin = 1'b0;
  logic [1:0]  laneA;
  logic [1:0]  laneB;
  logic        frameClk;
  logic        bitClk;

  int checks = 0;
  int fails = 0;
  int hiCnt;
  bit bBad;
  bit ckBad;
  bit endOk;

  always #5 clk = ~clk;

  adc_serial_fmt u_adc_serial_fmt (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .samples(samples),
    .cfgTwoLane(cfgTwoLane), .cfgLsbFirst(cfgLsbFirst), .cfgOffsetBin(cfgOffsetBin),
    .laneA(laneA), .laneB(laneB), .frameClk(frameClk), .bitClk(bitClk)
  );

  // {twoLane, lsbFirst, offsetBin, ch1 word, ch0 word}
  localparam logic [26:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 12'hA5C, 12'h3F1},
    {1'b1, 1'b0, 1'b1, 12'h800, 12'h7FF},
    {1'b1, 1'b1, 1'b0, 12'h123, 12'hFED},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'hFFF},
    {1'b0, 1'b0, 1'b0, 12'h5A5, 12'hC3C},
    {1'b0, 1'b0, 1'b1, 12'hFFF, 12'h001},
    {1'b0, 1'b1, 1'b0, 12'h0F0, 12'hE07},
    {1'b0, 1'b1, 1'b1, 12'h7FF, 12'h800}
  };

  function automatic logic [11:0] coded(input logic [11:0] s, input bit ob);
    return ob ? (s ^ 12'h800) : s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_frame_start();
    logic prev;
    prev = frameClk;
    forever begin
      @(negedge clk);
      if (frameClk && !prev) break;
      prev = frameClk;
    end
  endtask

  // Called at the negedge of a frame's first cycle; returns at the next frame's.
  task automatic capture(input bit two, input bit lsb,
                         output logic [11:0] r0, output logic [11:0] r1);
    int n;
    n = two ? 6 : 12;
    r0 = '0; r1 = '0;
    hiCnt = 0; bBad = 0; ckBad = 0;
    for (int b = 0; b < n; b++) begin
      int pa;
      int pb;
      @(negedge clk);
      if (!bitClk) ckBad = 1;
      hiCnt += int'(frameClk);
      if (two) begin
        pa = lsb ? 6 + b : 11 - b;
        pb = lsb ? b : 5 - b;
        r0[pb] = laneB[0];
        r1[pb] = laneB[1];
      end else begin
        pa = lsb ? b : 11 - b;
        if (laneB != 2'b00) bBad = 1;
      end
      r0[pa] = laneA[0];
      r1[pa] = laneA[1];
      @(negedge clk);
      if (bitClk) ckBad = 1;
    end
    endOk = frameClk;
  endtask

  task automatic frame_checks(input bit two, input logic [11:0] r0, input logic [11:0] r1,
                              input logic [11:0] e0, input logic [11:0] e1, input string tag);
    int n;
    n = two ? 6 : 12;
    chk(r0 == e0, tag, "ch0 word (R10)", r0, e0);
    chk(r1 == e1, tag, "ch1 word (R10)", r1, e1);
    chk(endOk, two ? "R3" : "R4", "frame length", endOk, 1);
    chk(hiCnt == n / 2, "R7", "frameClk high bits", hiCnt, n / 2);
    chk(!ckBad, "R2", "bitClk phase", ckBad, 0);
    if (!two) chk(!bBad, "R4", "laneB idle", bBad, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [11:0] r0;
    logic [11:0] r1;
    logic [11:0] s0;
    logic [11:0] s1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(laneA == 2'b00 && laneB == 2'b00, "R1", "lanes in reset", {laneA, laneB}, 0);
    chk(frameClk == 1'b1, "R1", "frameClk in reset", frameClk, 1);
    chk(bitClk == 1'b0, "R1", "bitClk in reset", bitClk, 0);
    rst_n = 1'b1;
    capture(1'b1, 1'b0, r0, r1);
    frame_checks(1'b1, r0, r1, 12'h000, 12'h000, "R1");

    // Table walk: all mode/order/coding combinations (R3 R4 R5 R6)
    for (int v = 0; v < 8; v++) begin
      logic two;
      logic lsb;
      logic ob;
      {two, lsb, ob, s1, s0} = VEC[v];
      cfgTwoLane = two; cfgLsbFirst = lsb; cfgOffsetBin = ob;
      samples = {s1, s0};
      sampleValid = 1'b1;
      wait_frame_start();
      sampleValid = 1'b0;
      capture(two, lsb, r0, r1);
      frame_checks(two, r0, r1, coded(s0, ob), coded(s1, ob), lsb ? "R5 R6" : "R6 R5");
    end

    // R8: config change in the middle of a frame
    cfgTwoLane = 1'b1; cfgLsbFirst = 1'b0; cfgOffsetBin = 1'b0;
    samples = {12'h9C6, 12'h35A};
    sampleValid = 1'b1;
    wait_frame_start();
    sampleValid = 1'b0;
    fork
      capture(1'b1, 1'b0, r0, r1);
      begin
        repeat (5) @(negedge clk);
        cfgTwoLane = 1'b0; cfgLsbFirst = 1'b1; cfgOffsetBin = 1'b1;
      end
    join
    frame_checks(1'b1, r0, r1, 12'h35A, 12'h9C6, "R8");
    // Next frame uses the new format and repeats the pair (R9)
    samples = {12'hBAD, 12'hBAD};
    capture(1'b0, 1'b1, r0, r1);
    frame_checks(1'b0, r0, r1, coded(12'h35A, 1'b1), coded(12'h9C6, 1'b1), "R8 R9");

    // R9: two strobes mid-frame; current frame unaffected, latest wins next
    fork
      capture(1'b0, 1'b1, r0, r1);
      begin
        repeat (3) @(negedge clk);
        samples = {12'h111, 12'h222}; sampleValid = 1'b1;
        @(negedge clk);
        sampleValid = 1'b0;
        repeat (2) @(negedge clk);
        samples = {12'h6E4, 12'h0C9}; sampleValid = 1'b1;
        @(negedge clk);
        sampleValid = 1'b0;
        samples = {12'hF0F, 12'hF0F};
      end
    join
    frame_checks(1'b0, r0, r1, coded(12'h35A, 1'b1), coded(12'h9C6, 1'b1), "R9");
    capture(1'b0, 1'b1, r0, r1);
    frame_checks(1'b0, r0, r1, coded(12'h0C9, 1'b1), coded(12'h6E4, 1'b1), "R9");
    capture(1'b0, 1'b1, r0, r1);
    frame_checks(1'b0, r0, r1, coded(12'h0C9, 1'b1), coded(12'h6E4, 1'b1), "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule